// File: doc/BRIEF.md
# Cube Map Face Selector

This unit takes the three single-precision components of a direction vector and finds the component with the largest magnitude. It then reports which of the six cube faces the vector points at. The face number is two times the axis index (x is 0, y is 1, z is 2). One is added when the winning component is negative. The number is returned as a single-precision float bit pattern, not as an integer, so a floating-point datapath can use it directly.

The unit has no handshake. Each cycle where `in_valid` is high, the unit captures a result, and `out_valid` rises on the next clock. When `in_valid` is low, the result register keeps its last value.

Top module: `cube_face_pick`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. A synchronous active-low reset clears both `out_valid` and `face_code` to 0.
- R2: z is chosen when its magnitude is greater than or equal to both the y and the x magnitudes. A tie with either of them therefore goes to z.
- R3: When z is not chosen, y is chosen if its magnitude is greater than or equal to the x magnitude. Otherwise x is chosen, so a y/x tie goes to y.
- R4: A magnitude is bits [30:0] of the component, read as an unsigned integer. Infinity (0x7F800000 without the sign bit) is larger than every finite value.
- R5: The face number is 2·axis when the chosen component is non-negative and 2·axis+1 when it is negative. +0.0 and -0.0 both count as non-negative.
- R6: `face_code` is the float bit pattern of the face number: 0→0x00000000, 1→0x3F800000, 2→0x40000000, 3→0x40400000, 4→0x40800000, 5→0x40A00000.
- R7: A NaN has exponent bits [30:23] all ones and a non-zero fraction. Any comparison that involves a NaN is false. If a NaN component is still chosen, it takes the odd (negative) code, because its sign test fails.
- R8: While `in_valid` is low, `face_code` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input vector present this cycle |
| vec_x | input | 32 | x component, IEEE-754 single |
| vec_y | input | 32 | y component, IEEE-754 single |
| vec_z | input | 32 | z component, IEEE-754 single |
| out_valid | output | 1 | Result valid (in_valid one cycle later) |
| face_code | output | 32 | Face number as IEEE-754 single |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid delay;
- that the output is always one of the six legal codes;
- that the result holds during idle cycles;
- that a z which meets or exceeds both other magnitudes always gives face 4 or 5;
- that a NaN z never gives face 4 or 5 when x and y are ordinary numbers.

Several behaviours can only be shown by the bench's scenarios, where a behavioural reference model is compared every clock:
- the y-over-x tie order;
- the signed-zero sign test;
- the order of infinities against finite values;
- the exact NaN fall-through paths;
- the reset values.

// File: rtl/cube_face_pick.sv
module cube_face_pick (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] vec_x,
  input  logic [31:0] vec_y,
  input  logic [31:0] vec_z,
  output logic        out_valid,
  output logic [31:0] face_code
);

  localparam logic [31:0] FACE0 = 32'h0000_0000;
  localparam logic [31:0] FACE1 = 32'h3F80_0000;
  localparam logic [31:0] FACE2 = 32'h4000_0000;
  localparam logic [31:0] FACE3 = 32'h4040_0000;
  localparam logic [31:0] FACE4 = 32'h4080_0000;
  localparam logic [31:0] FACE5 = 32'h40A0_0000;

  function automatic logic nan_of(input logic [31:0] v);
    return (&v[30:23]) && (|v[22:0]);
  endfunction

  function automatic logic ge_mag(input logic [31:0] a, input logic [31:0] b);
    return !nan_of(a) && !nan_of(b) && (a[30:0] >= b[30:0]);
  endfunction

  function automatic logic nonneg(input logic [31:0] v);
    return !nan_of(v) && (!v[31] || (v[30:0] == 31'd0));
  endfunction

  logic        z_wins, y_wins;
  logic [31:0] next_code;

  assign z_wins = ge_mag(vec_z, vec_y) && ge_mag(vec_z, vec_x);
  assign y_wins = !z_wins && ge_mag(vec_y, vec_x);

  always_comb begin
    if (z_wins)      next_code = nonneg(vec_z) ? FACE4 : FACE5;
    else if (y_wins) next_code = nonneg(vec_y) ? FACE2 : FACE3;
    else             next_code = nonneg(vec_x) ? FACE0 : FACE1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      face_code <= FACE0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) face_code <= next_code;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (face_code == FACE0 || face_code == FACE1 || face_code == FACE2 ||
                   face_code == FACE3 || face_code == FACE4 || face_code == FACE5)); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $past(rst_n)) |=> $stable(face_code)); // R8

  AST_Z_TIES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !nan_of(vec_x) && !nan_of(vec_y) && !nan_of(vec_z) &&
     vec_z[30:0] >= vec_y[30:0] && vec_z[30:0] >= vec_x[30:0])
    |=> (face_code == FACE4 || face_code == FACE5)); // R2

  AST_NAN_Z_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nan_of(vec_z) && !nan_of(vec_x) && !nan_of(vec_y))
    |=> (face_code != FACE4 && face_code != FACE5)); // R7

endmodule

// File: tb/cube_face_pick_test.sv
module cube_face_pick_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] vec_x = '0, vec_y = '0, vec_z = '0;
  logic        out_valid;
  logic [31:0] face_code;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cube_face_pick uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .vec_x(vec_x), .vec_y(vec_y), .vec_z(vec_z),
    .out_valid(out_valid), .face_code(face_code));

  // behavioural reference
  function automatic bit is_nan(input logic [31:0] v);
    return v[30:23] == 8'hFF && v[22:0] != 0;
  endfunction

  function automatic bit ordered_ge(input logic [31:0] a, input logic [31:0] b);
    longint ma, mb;
    if (is_nan(a) || is_nan(b)) return 0;
    ma = a & 32'h7FFF_FFFF;
    mb = b & 32'h7FFF_FFFF;
    return ma >= mb;
  endfunction

  function automatic bit at_least_zero(input logic [31:0] v);
    if (is_nan(v)) return 0;
    if ((v & 32'h7FFF_FFFF) == 0) return 1;
    return v[31] == 0;
  endfunction

  function automatic logic [31:0] int_to_float(input int n);
    int e;
    logic [31:0] r;
    if (n == 0) return 32'h0;
    e = 0;
    while ((n >> (e + 1)) != 0) e++;
    r = 0;
    r[30:23] = 8'(127 + e);
    r[22:0] = 23'((n << (23 - e)) & 32'h7F_FFFF);
    return r;
  endfunction

  function automatic int ref_face(input logic [31:0] x, input logic [31:0] y, input logic [31:0] z);
    if (ordered_ge(z, y) && ordered_ge(z, x)) return at_least_zero(z) ? 4 : 5;
    if (ordered_ge(y, x)) return at_least_zero(y) ? 2 : 3;
    return at_least_zero(x) ? 0 : 1;
  endfunction

  logic        exp_valid = 0;
  logic [31:0] exp_code = 0;
  string       exp_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid <= 0;
      exp_code  <= 0;
    end else begin
      exp_valid <= in_valid;
      if (in_valid) begin
        exp_code <= int_to_float(ref_face(vec_x, vec_y, vec_z));
        exp_tag  <= (is_nan(vec_x) || is_nan(vec_y) || is_nan(vec_z)) ? "R7" :
                    (ordered_ge(vec_z, vec_y) && ordered_ge(vec_z, vec_x)) ? "R2/R5/R6" : "R3/R4/R5/R6";
      end else exp_tag <= "R8";
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R1 valid", {31'b0, out_valid}, {31'b0, exp_valid});
    check(exp_tag, face_code, exp_code);
  end

  task automatic drive(input bit v, input logic [31:0] x, input logic [31:0] y, input logic [31:0] z);
    @(negedge clk);
    #1;
    in_valid = v; vec_x = x; vec_y = y; vec_z = z;
  endtask

  function automatic logic [31:0] pick_special(input int unsigned r);
    case (r % 10)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h7F80_0000;
      3: return 32'hFF80_0000;
      4: return 32'h7FC0_0001;
      5: return 32'h3F80_0000;
      6: return 32'hBF80_0000;
      7: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #40000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", {31'b0, out_valid}, 32'h0);
    check("R1 reset code", face_code, 32'h0);
    rst_n = 1;
    // R2 ties to z
    drive(1, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000);
    drive(1, 32'hC000_0000, 32'h4000_0000, 32'hC000_0000);
    // R3 y over x tie, x alone
    drive(1, 32'h4000_0000, 32'hC000_0000, 32'h3F80_0000);
    drive(1, 32'hC040_0000, 32'h4000_0000, 32'h3F80_0000);
    drive(1, 32'h4040_0000, 32'h4000_0000, 32'h3F80_0000);
    // R5 signed zeros
    drive(1, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000);
    drive(1, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000);
    // R4 infinity and tiny denormals
    drive(1, 32'hFF80_0000, 32'h7F7F_FFFF, 32'h0000_0001);
    drive(1, 32'h0000_0001, 32'h8000_0002, 32'h0000_0000);
    // R7 NaN cases
    drive(1, 32'h3F80_0000, 32'h4000_0000, 32'h7FC0_0000);
    drive(1, 32'h7FC0_0000, 32'h3F80_0000, 32'h3F80_0000);
    drive(1, 32'h3F80_0000, 32'hFFC0_0000, 32'h0000_0000);
    // R8 idle holds
    drive(0, 32'hBF80_0000, 32'h0, 32'h0);
    drive(0, 32'h0, 32'h0, 32'hC000_0000);
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom;
      drive((r % 4) != 0, pick_special($urandom), pick_special($urandom), pick_special($urandom));
    end
    drive(0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule